// File: doc/BRIEF.md
# Video Control Signal Conditioner

This block sits on the pixel clock of a parallel video input and cleans up the two control strobes that travel with the pixels: data-enable and vertical sync. When qualification is switched on, a data-enable level has to hold for a minimum number of consecutive pixel clocks before it reaches the output. A glitch shorter than that never appears, and the output keeps its previous level. When qualification is off, data-enable passes straight through. Both strobes leave the block with the same fixed latency in either mode, so they stay aligned with pixel data that a matching pipeline delays.

In parallel, the block watches how often each raw strobe changes state. Data-enable may toggle at most twice, and vertical sync at most once, in any window of 130 consecutive pixel clocks. A faster change sets a sticky violation flag for that strobe. A one-cycle clear pulse drops the flag.

Top module: `vctl_filter`

## Requirements
- R1: With qualification active, `de_out` takes a new level only after `de_in` has been sampled at that level on 3 consecutive rising edges. A shorter run leaves `de_out` at its previous level.
- R2: Qualification is active after reset. `qual_en` is sampled on each rising edge and governs the output update one edge later. When qualification turns on in the middle of a pulse, the partial run is not passed on, and `de_out` holds until a full qualifying run is seen.
- R3: With qualification inactive, a value of `de_in` sampled at rising edge k appears on `de_out` after rising edge k+3. This includes single-clock pulses.
- R4: A value of `vs_in` sampled at rising edge k appears on `vs_out` after rising edge k+3, whatever the qualification setting.
- R5: A transition of `de_in` that comes less than 130 sampled clocks after the transition two before it sets `de_rate_err`. Transitions 130 or more clocks apart do not set it.
- R6: A transition of `vs_in` that comes less than 130 sampled clocks after the previous transition sets `vs_rate_err`.
- R7: Both violation flags are sticky. A high `flag_clr` at a rising edge clears them, and a violation detected at the same edge takes priority over the clear.
- R8: While `rst_n` is low, `de_out`, `vs_out`, `de_rate_err` and `vs_rate_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual_en | input | 1 | 1 = minimum-width qualification of data-enable, 0 = pass-through |
| de_in | input | 1 | Raw data-enable |
| vs_in | input | 1 | Raw vertical sync |
| flag_clr | input | 1 | One-cycle pulse that clears both violation flags |
| de_out | output | 1 | Conditioned, delayed data-enable |
| vs_out | output | 1 | Delayed vertical sync |
| de_rate_err | output | 1 | Sticky data-enable transition-rate violation |
| vs_rate_err | output | 1 | Sticky vertical-sync transition-rate violation |

## Verification
On every cycle, the assertions check the following. A qualified data-enable edge is always preceded by a full run of equal input samples. A violation flag only rises after a sampled transition. Once set, a flag stays set until a clear, and a clear with no transition present drops it. The exact 3-clock alignment of both paths, the pass-through of single-clock pulses, the discarding of partial runs when the mode changes, and the exact 130-clock window boundaries can only be shown by the bench. It compares every output, on every cycle, against a timestamp-based model under directed and random stimulus.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

   typedef enum logic {
      MODE_PASS = 1'b0,
      MODE_QUAL = 1'b1
   } qual_mode_e;

endpackage

// File: rtl/vctl_delay_line.sv
module vctl_delay_line #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("vctl_delay_line: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= 1'b0;
      else        stg_q[0] <= din;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[i] <= 1'b0;
         else        stg_q[i] <= stg_q[i-1];
      end
   end

   assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/vctl_pulse_qual.sv
module vctl_pulse_qual
   import vctl_pkg::*;
#(
   parameter int MIN_WIDTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic dout
);

   localparam int RW = $clog2(MIN_WIDTH + 1);

   if (MIN_WIDTH < 1) begin : g_bad_width
      $error("vctl_pulse_qual: MIN_WIDTH must be at least 1");
   end

   logic [MIN_WIDTH-1:0] win_q;
   qual_mode_e           mode_q;
   logic                 out_q;
   logic                 out_d;
   logic                 all_hi;
   logic                 all_lo;

   // sample window, newest in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q[0] <= 1'b0;
      else        win_q[0] <= din;
   end

   for (genvar i = 1; i < MIN_WIDTH; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_q[i] <= 1'b0;
         else        win_q[i] <= win_q[i-1];
      end
   end

   // mode register: qualification on out of reset, new setting used one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_QUAL;
      else        mode_q <= en ? MODE_QUAL : MODE_PASS;
   end

   assign all_hi = &win_q;
   assign all_lo = ~|win_q;

   always_comb begin
      out_d = out_q;
      if (mode_q == MODE_QUAL) begin
         if (all_hi)      out_d = 1'b1;
         else if (all_lo) out_d = 1'b0;
      end else begin
         out_d = win_q[MIN_WIDTH-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end

   assign dout = out_q;

   // run-length observers for the checks below
   logic [RW-1:0] hi_run_q;
   logic [RW-1:0] lo_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q <= '0;
         lo_run_q <= '0;
      end else begin
         hi_run_q <= !din ? '0 : ((int'(hi_run_q) >= MIN_WIDTH) ? hi_run_q : hi_run_q + 1'b1);
         lo_run_q <= din  ? '0 : ((int'(lo_run_q) >= MIN_WIDTH) ? lo_run_q : lo_run_q + 1'b1);
      end
   end

   // R1
   qual_rise_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_q) && $past(mode_q == MODE_QUAL)) |-> (int'($past(hi_run_q)) >= MIN_WIDTH));

   // R1
   qual_fall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(out_q) && $past(mode_q == MODE_QUAL)) |-> (int'($past(lo_run_q)) >= MIN_WIDTH));

endmodule

// File: rtl/vctl_rate_mon.sv
module vctl_rate_mon #(
   parameter int WINDOW    = 130,
   parameter int MAX_EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic clr,
   output logic flag
);

   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] FAR = CW'(WINDOW);

   if (WINDOW < 2) begin : g_bad_window
      $error("vctl_rate_mon: WINDOW must be at least 2");
   end
   if (MAX_EDGES < 1) begin : g_bad_edges
      $error("vctl_rate_mon: MAX_EDGES must be at least 1");
   end

   function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
      return (v >= FAR) ? FAR : v + 1'b1;
   endfunction

   logic smp_q;
   logic prv_q;
   logic edge_w;
   logic viol_w;
   logic flag_q;
   logic [CW-1:0] dist_q [MAX_EDGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= 1'b0;
         prv_q <= 1'b0;
      end else begin
         smp_q <= din;
         prv_q <= smp_q;
      end
   end

   assign edge_w = smp_q ^ prv_q;
   // distance from the oldest remembered transition to this one
   assign viol_w = edge_w && ((int'(dist_q[MAX_EDGES-1]) + 1) < WINDOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dist_q[0] <= FAR;
      else if (edge_w) dist_q[0] <= '0;
      else             dist_q[0] <= sat_inc(dist_q[0]);
   end

   for (genvar k = 1; k < MAX_EDGES; k++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dist_q[k] <= FAR;
         else if (edge_w) dist_q[k] <= sat_inc(dist_q[k-1]);
         else             dist_q[k] <= sat_inc(dist_q[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (viol_w) flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_w) |=> !flag_q);

   // R5
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(edge_w));

endmodule

// File: rtl/vctl_filter.sv
module vctl_filter #(
   parameter int MIN_WIDTH = 3,
   parameter int WINDOW    = 130,
   parameter int DE_EDGES  = 2,
   parameter int VS_EDGES  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_en,
   input  logic de_in,
   input  logic vs_in,
   input  logic flag_clr,
   output logic de_out,
   output logic vs_out,
   output logic de_rate_err,
   output logic vs_rate_err
);

   // qualifier window plus its output register
   localparam int PIPE = MIN_WIDTH + 1;

   vctl_pulse_qual #(.MIN_WIDTH(MIN_WIDTH)) i_de_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (qual_en),
      .din  (de_in),
      .dout (de_out)
   );

   vctl_delay_line #(.DEPTH(PIPE)) i_vs_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (vs_in),
      .dout (vs_out)
   );

   vctl_rate_mon #(.WINDOW(WINDOW), .MAX_EDGES(DE_EDGES)) i_de_rate (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (de_in),
      .clr  (flag_clr),
      .flag (de_rate_err)
   );

   vctl_rate_mon #(.WINDOW(WINDOW), .MAX_EDGES(VS_EDGES)) i_vs_rate (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (vs_in),
      .clr  (flag_clr),
      .flag (vs_rate_err)
   );

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !(de_out || vs_out || de_rate_err || vs_rate_err));

endmodule

// File: tb/test_vctl_filter.sv
module test_vctl_filter;

   localparam int WIN = 130;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic qual_en = 1'b1;
   logic de_in = 1'b0;
   logic vs_in = 1'b0;
   logic flag_clr = 1'b0;
   logic de_out, vs_out, de_rate_err, vs_rate_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vctl_filter i_vctl_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_en    (qual_en),
      .de_in      (de_in),
      .vs_in      (vs_in),
      .flag_clr   (flag_clr),
      .de_out     (de_out),
      .vs_out     (vs_out),
      .de_rate_err(de_rate_err),
      .vs_rate_err(vs_rate_err)
   );

   // ---------------- reference model from the requirements ----------------
   bit m_mode, m_used_qual;
   bit d1, d2, d3, v1, v2, v3;
   bit e_de, e_vs, e_def, e_vsf;
   int n;
   int de_l1, de_l2, vs_l1;
   localparam int NONE = -1000000;

   function automatic bit too_close(int s, int ref_t);
      return (s - ref_t) < WIN;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 1'b1; m_used_qual = 1'b1;
         d1 = 0; d2 = 0; d3 = 0; v1 = 0; v2 = 0; v3 = 0;
         e_de = 0; e_vs = 0; e_def = 0; e_vsf = 0;
         n = 0; de_l1 = NONE; de_l2 = NONE; vs_l1 = NONE;
      end else begin
         bit dv, vv;
         dv = 1'b0; vv = 1'b0;
         m_used_qual = m_mode;
         if (m_mode) begin
            if (d1 && d2 && d3)        e_de = 1'b1;
            else if (!d1 && !d2 && !d3) e_de = 1'b0;
         end else begin
            e_de = d3;
         end
         e_vs = v3;
         if (d1 != d2) begin
            if (too_close(n - 1, de_l2)) dv = 1'b1;
            de_l2 = de_l1; de_l1 = n - 1;
         end
         if (v1 != v2) begin
            if (too_close(n - 1, vs_l1)) vv = 1'b1;
            vs_l1 = n - 1;
         end
         e_def = dv ? 1'b1 : (flag_clr ? 1'b0 : e_def);
         e_vsf = vv ? 1'b1 : (flag_clr ? 1'b0 : e_vsf);
         m_mode = qual_en;
         d3 = d2; d2 = d1; d1 = de_in;
         v3 = v2; v2 = v1; v1 = vs_in;
         n++;
      end
   end

   task automatic check(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s at t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            // R8
            check(de_out, 1'b0, "R8", "de_out in reset");
            check(vs_out, 1'b0, "R8", "vs_out in reset");
            check(de_rate_err | vs_rate_err, 1'b0, "R8", "flags in reset");
         end else begin
            check(de_out, e_de, m_used_qual ? "R1" : "R3", "de_out");
            check(vs_out, e_vs, "R4", "vs_out");
            check(de_rate_err, e_def, "R5", "de_rate_err");
            check(vs_rate_err, e_vsf, "R6", "vs_rate_err");
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic hold(input logic de, input logic vs, input int k);
      de_in = de; vs_in = vs;
      repeat (k) @(negedge clk);
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      hold(0, 0, 5);
      // R1: qualifying 3-clock pulse, then 2- and 1-clock glitches
      hold(1, 0, 3); hold(0, 0, 8);
      hold(1, 0, 2); hold(0, 0, 8);
      hold(1, 0, 1); hold(0, 0, 8);
      hold(1, 0, 20); hold(0, 0, 1); hold(1, 0, 10); hold(0, 0, 200);
      pulse_clr();
      // R3: pass-through of single-clock pulses
      qual_en = 1'b0;
      hold(0, 0, 3); hold(1, 0, 1); hold(0, 0, 6); hold(1, 0, 2); hold(0, 0, 200);
      pulse_clr();
      // R2: enable qualification in the middle of a pulse
      hold(1, 0, 1); qual_en = 1'b1; hold(1, 0, 1); hold(0, 0, 10);
      hold(1, 0, 2); qual_en = 1'b0; hold(1, 0, 2); qual_en = 1'b1; hold(0, 0, 10);
      hold(0, 0, 200); pulse_clr();
      // R5: edges exactly at the window boundary, then one inside it
      hold(1, 0, 70); hold(0, 0, 70); hold(1, 0, 60); hold(0, 0, 60); hold(1, 0, 200);
      // R7: clear while flag set, then clear coinciding with a violation
      pulse_clr(); hold(1, 0, 5);
      hold(0, 0, 3); hold(1, 0, 3); flag_clr = 1'b1; hold(0, 0, 1); flag_clr = 1'b0;
      hold(0, 0, 20); pulse_clr(); hold(0, 0, 300);
      // R6: vertical sync pulses at and below the limit
      hold(0, 1, 130); hold(0, 0, 129); hold(0, 1, 10); hold(0, 0, 200);
      pulse_clr(); hold(0, 0, 200);
      // random mix, fixed seed
      begin
         int unsigned seed_v;
         int de_run, vs_run;
         seed_v = $urandom(32'h5EED_0A17);
         de_run = 1; vs_run = 150;
         for (int c = 0; c < 20000; c++) begin
            if (--de_run == 0) begin
               de_in = ~de_in;
               de_run = ($urandom % 8 == 0) ? 40 + $urandom % 120 : 1 + $urandom % 5;
            end
            if (--vs_run == 0) begin
               vs_in = ~vs_in;
               vs_run = 100 + $urandom % 200;
            end
            if ($urandom % 300 == 0) qual_en = ~qual_en;
            flag_clr = ($urandom % 150 == 0);
            @(negedge clk);
         end
         flag_clr = 1'b0;
      end
      hold(0, 0, 10);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule